// File: doc/BRIEF.md
# Snapshot-Read Event Counter Bank

This block holds eight 20-bit event counters behind a byte-wide register port. Each counter has its own increment strobe and counts one event per clock in which its strobe is high. Software reads a counter through three byte reads. Reading the least significant byte copies the upper twelve bits of that counter into one holding register shared by the whole bank. The middle and upper bytes are then read from that holding register. The three bytes therefore always belong to one value, even if the counter keeps moving between the accesses.

The counters have no reset. A synchronous reset clears the read data, the holding register and the interrupt pulses, and leaves every count where it was. To preset the counters, software raises stop mode. While stop mode is high, counting is frozen and any byte of any counter can be written, in any order. Each counter drives two interrupt pulses: one for every accepted increment, and one when the count rolls over from its maximum to zero.

Top module: `evcnt_bank`

## Requirements
- R1: When `stop_mode` is low and `inc_strobe[i]` is high at a clock edge, counter i advances by one, and `inc_irq[i]` is high for the following cycle only.
- R2: A counter at 0xFFFFF that takes an accepted increment becomes 0. `wrap_irq[i]` is then high for one cycle, together with `inc_irq[i]`.
- R3: While `stop_mode` is high, increment strobes have no effect on the counts, and both interrupt outputs stay low.
- R4: Counter i occupies byte addresses 0xA0+4i to 0xA3+4i, and the low two address bits select the byte: 0 is a zero byte, 1 is bits 19-16 in bits 3-0, 2 is bits 15-8, 3 is bits 7-0. A write (`cs`=1, `wr`=1) while `stop_mode` is high replaces the selected byte. A write while `stop_mode` is low changes nothing.
- R5: A read of byte 3 returns the live bits 7-0 of that counter. In the same access it loads bits 19-8 of that counter into the holding register.
- R6: Reads of byte 1 or byte 2 of any counter return the holding register, not the live count. The holding register is shared, so byte 1 of counter j returns bits taken from whichever counter's byte 3 was read last.
- R7: Bits 7-4 of byte 1 read as zero, and data written to them is dropped. Byte 0 always reads as zero, and writes to it are dropped.
- R8: Reads of any address outside 0xA0-0xBF return zero.
- R9: Reset clears `rdata`, the holding register, `inc_irq` and `wrap_irq`, but does not change any count. Counting and writes are held off while reset is high.
- R10: `rdata` presents the result of a read in the cycle after the access and is zero in every cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset (does not clear counts) |
| stop_mode | input | 1 | Freezes counting and enables counter writes |
| inc_strobe | input | 8 | One increment request per counter |
| cs | input | 1 | Register access in this cycle |
| wr | input | 1 | 1 = write access, 0 = read access |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one cycle after the read |
| inc_irq | output | 8 | One-cycle pulse per accepted increment |
| wrap_irq | output | 8 | One-cycle pulse per rollover to zero |

## Verification
The bound checker watches several rules on every cycle. It checks the step-by-one and rollover arithmetic of each counter, the freeze of all counts in stop mode when no write is made, and the silence of the interrupt outputs in stop mode. It also checks the zero upper nibble, the zero result for idle cycles and reserved addresses, and that a rollover pulse never comes without its increment pulse. Some properties depend on earlier accesses, and only the bench scenarios can show them. These are that a snapshot stays intact while its counter keeps moving, that one counter's snapshot can be read at another counter's addresses, that writes outside stop mode are dropped, and that counts survive a reset.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

    localparam int NUM_CNT   = 8;
    localparam int CNT_W     = 20;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int IDX_W     = $clog2(NUM_CNT);
    localparam int HOLD_W    = CNT_W - DATA_W;
    localparam int TOP_W     = CNT_W - 2 * DATA_W;
    localparam int SPAN      = NUM_CNT * 4;
    localparam logic [ADDR_W-1:0] BASE_ADDR = 8'hA0;

    typedef enum logic [1:0] {
        SEL_ZERO = 2'd0,
        SEL_TOP  = 2'd1,
        SEL_MID  = 2'd2,
        SEL_LOW  = 2'd3
    } byte_sel_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        byte_sel_e        sel;
    } addr_dec_t;

    function automatic addr_dec_t decode_addr(logic [ADDR_W-1:0] a);
        addr_dec_t       d;
        logic [ADDR_W-1:0] rel;
        rel   = a - BASE_ADDR;
        d.hit = (a >= BASE_ADDR) && (rel < ADDR_W'(SPAN));
        d.idx = rel[IDX_W+1:2];
        d.sel = byte_sel_e'(rel[1:0]);
        return d;
    endfunction

endpackage

// File: rtl/evcnt_cell.sv
module evcnt_cell #(
    parameter int CNT_W  = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_mode,
    input  logic              inc,
    input  logic              wr_top,
    input  logic              wr_mid,
    input  logic              wr_low,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic              inc_irq,
    output logic              wrap_irq
);
    localparam int TOP_W = CNT_W - 2 * DATA_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic at_max;
    logic take_inc;

    assign at_max   = (count == CNT_MAX);
    assign take_inc = inc && !stop_mode;

    // The count has no reset on purpose: it must survive a block reset.
    always_ff @(posedge clk) begin
        if (!rst) begin
            if (stop_mode) begin
                if (wr_top) count[CNT_W-1:2*DATA_W]    <= wdata[TOP_W-1:0];
                if (wr_mid) count[2*DATA_W-1:DATA_W]   <= wdata;
                if (wr_low) count[DATA_W-1:0]          <= wdata;
            end else if (inc) begin
                count <= at_max ? '0 : count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inc_irq  <= 1'b0;
            wrap_irq <= 1'b0;
        end else begin
            inc_irq  <= take_inc;
            wrap_irq <= take_inc && at_max;
        end
    end

endmodule

// File: rtl/evcnt_rdpath.sv
module evcnt_rdpath
    import evcnt_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             rd_en,
    input  addr_dec_t                        dec,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]    counts,
    output logic [DATA_W-1:0]                rdata,
    output logic [HOLD_W-1:0]                hold
);
    logic [CNT_W-1:0] picked;

    assign picked = counts[dec.idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            hold  <= '0;
        end else begin
            rdata <= '0;
            if (rd_en && dec.hit) begin
                unique case (dec.sel)
                    SEL_LOW: begin
                        rdata <= picked[DATA_W-1:0];
                        hold  <= picked[CNT_W-1:DATA_W];
                    end
                    SEL_MID:  rdata <= hold[DATA_W-1:0];
                    SEL_TOP:  rdata <= DATA_W'(hold[HOLD_W-1:DATA_W]);
                    default:  rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
    import evcnt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               stop_mode,
    input  logic [NUM_CNT-1:0] inc_strobe,
    input  logic               cs,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [NUM_CNT-1:0] inc_irq,
    output logic [NUM_CNT-1:0] wrap_irq
);
    addr_dec_t                     dec;
    logic                          wr_go;
    logic                          rd_go;
    logic [NUM_CNT-1:0][CNT_W-1:0] counts;
    logic [HOLD_W-1:0]             hold;

    assign dec   = decode_addr(addr);
    assign wr_go = cs && wr && dec.hit;
    assign rd_go = cs && !wr;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic mine;
        assign mine = wr_go && (dec.idx == IDX_W'(i));

        evcnt_cell #(
            .CNT_W  (CNT_W),
            .DATA_W (DATA_W)
        ) i_cell (
            .clk       (clk),
            .rst       (rst),
            .stop_mode (stop_mode),
            .inc       (inc_strobe[i]),
            .wr_top    (mine && dec.sel == SEL_TOP),
            .wr_mid    (mine && dec.sel == SEL_MID),
            .wr_low    (mine && dec.sel == SEL_LOW),
            .wdata     (wdata),
            .count     (counts[i]),
            .inc_irq   (inc_irq[i]),
            .wrap_irq  (wrap_irq[i])
        );
    end

    evcnt_rdpath i_rdpath (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_go),
        .dec    (dec),
        .counts (counts),
        .rdata  (rdata),
        .hold   (hold)
    );

endmodule

// File: rtl/evcnt_bank_chk.sv
module evcnt_bank_chk
    import evcnt_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          stop_mode,
    input logic [NUM_CNT-1:0]            inc_strobe,
    input logic                          cs,
    input logic                          wr,
    input logic [ADDR_W-1:0]             addr,
    input logic [DATA_W-1:0]             rdata,
    input logic [NUM_CNT-1:0]            inc_irq,
    input logic [NUM_CNT-1:0]            wrap_irq,
    input logic [NUM_CNT-1:0][CNT_W-1:0] counts
);
    localparam int LAST_ADDR = int'(BASE_ADDR) + SPAN - 1;
    localparam logic [CNT_W-1:0] TOPV = {CNT_W{1'b1}};

    logic in_map;
    assign in_map = (int'(addr) >= int'(BASE_ADDR)) && (int'(addr) <= LAST_ADDR);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_per
        AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
            (!stop_mode && inc_strobe[i] && counts[i] != TOPV)
            |=> (counts[i] == $past(counts[i]) + 1'b1) && inc_irq[i]) // R1
            else $error("step");
        AST_ROLL_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
            (!stop_mode && inc_strobe[i] && counts[i] == TOPV)
            |=> (counts[i] == '0) && wrap_irq[i]) // R2
            else $error("roll");
    end

    AST_WRAP_NEEDS_INC: assert property (@(posedge clk) disable iff (rst)
        (wrap_irq & ~inc_irq) == '0) // R2
        else $error("wrap without inc");

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && !(cs && wr)) |=> $stable(counts)) // R3
        else $error("freeze");

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        stop_mode |=> (inc_irq == '0) && (wrap_irq == '0)) // R3
        else $error("quiet");

    AST_NULL_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        (cs && !wr && in_map && addr[1:0] == 2'd1) |=> (rdata[7:4] == 4'd0)) // R7
        else $error("nibble");

    AST_ZERO_BYTE: assert property (@(posedge clk) disable iff (rst)
        (cs && !wr && in_map && addr[1:0] == 2'd0) |=> (rdata == '0)) // R7
        else $error("zero byte");

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cs && !wr && !in_map) |=> (rdata == '0)) // R8
        else $error("reserved");

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !(cs && !wr) |=> (rdata == '0)) // R10
        else $error("idle");

endmodule

bind evcnt_bank evcnt_bank_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .stop_mode  (stop_mode),
    .inc_strobe (inc_strobe),
    .cs         (cs),
    .wr         (wr),
    .addr       (addr),
    .rdata      (rdata),
    .inc_irq    (inc_irq),
    .wrap_irq   (wrap_irq),
    .counts     (counts)
);

// File: tb/test_evcnt_bank.sv
`timescale 1ns/1ps
module test_evcnt_bank;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stop_mode = 1'b0;
    logic [7:0] inc_strobe = '0;
    logic       cs = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] inc_irq;
    logic [7:0] wrap_irq;

    int    checks = 0;
    int    fails  = 0;
    bit    cmp_on = 1'b0;
    string cur_tag = "R9";

    // reference model state
    int unsigned m_cnt [8];
    int unsigned m_hold = 0;
    logic [7:0]  e_rd = '0;
    logic [7:0]  e_inc = '0;
    logic [7:0]  e_wrap = '0;
    string       e_tag = "R9";

    int unsigned known [8];

    always #2.5 clk = ~clk;

    evcnt_bank i_evcnt_bank (
        .clk(clk), .rst(rst), .stop_mode(stop_mode), .inc_strobe(inc_strobe),
        .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .inc_irq(inc_irq), .wrap_irq(wrap_irq)
    );

    always @(posedge clk) begin : model
        int rel;
        int k;
        e_tag = cur_tag;
        if (rst) begin
            e_rd = '0; m_hold = 0; e_inc = '0; e_wrap = '0;
        end else begin
            rel  = int'(addr) - 'hA0;
            e_rd = '0;
            if (cs && !wr && rel >= 0 && rel < 32) begin
                k = rel / 4;
                case (rel % 4)
                    3: begin e_rd = 8'(m_cnt[k] & 'hFF); m_hold = (m_cnt[k] >> 8) & 'hFFF; end
                    2: e_rd = 8'(m_hold & 'hFF);
                    1: e_rd = 8'((m_hold >> 8) & 'hF);
                    default: e_rd = '0;
                endcase
            end
            if (stop_mode && cs && wr && rel >= 0 && rel < 32) begin
                k = rel / 4;
                case (rel % 4)
                    1: m_cnt[k] = (m_cnt[k] & 'h0FFFF) | ((int'(wdata) & 'hF) << 16);
                    2: m_cnt[k] = (m_cnt[k] & 'hF00FF) | (int'(wdata) << 8);
                    3: m_cnt[k] = (m_cnt[k] & 'hFFF00) | int'(wdata);
                    default: ;
                endcase
            end
            for (int i = 0; i < 8; i++) begin
                e_inc[i] = 1'b0; e_wrap[i] = 1'b0;
                if (!stop_mode && inc_strobe[i]) begin
                    e_inc[i] = 1'b1;
                    if (m_cnt[i] == 'hFFFFF) begin m_cnt[i] = 0; e_wrap[i] = 1'b1; end
                    else m_cnt[i] = m_cnt[i] + 1;
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (rdata !== e_rd || inc_irq !== e_inc || wrap_irq !== e_wrap) begin
                fails++;
                $display("FAIL %s: rdata=%h inc=%b wrap=%b expected rdata=%h inc=%b wrap=%b",
                         e_tag, rdata, inc_irq, wrap_irq, e_rd, e_inc, e_wrap);
            end
        end
    end

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(input bit c, input bit w, input logic [7:0] a,
                       input logic [7:0] d, input logic [7:0] s, input string tag);
        @(negedge clk);
        cs = c; wr = w; addr = a; wdata = d; inc_strobe = s; cur_tag = tag;
    endtask

    task automatic put(input logic [7:0] a, input logic [7:0] d, input string tag);
        cyc(1'b1, 1'b1, a, d, 8'h00, tag);
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [7:0] e, input string tag);
        cyc(1'b1, 1'b0, a, 8'h00, 8'h00, tag);
        @(negedge clk);
        cs = 1'b0; inc_strobe = '0;
        check(rdata, e, tag);
    endtask

    task automatic set_stop(input bit v);
        @(negedge clk);
        stop_mode = v; cs = 1'b0; inc_strobe = '0;
    endtask

    task automatic read_all(input int i, input string tag);
        logic [7:0] b;
        b = 8'hA0 + 8'(4 * i);
        rd_expect(b + 8'd3, 8'(known[i] & 'hFF), tag);
        rd_expect(b + 8'd2, 8'((known[i] >> 8) & 'hFF), tag);
        rd_expect(b + 8'd1, 8'((known[i] >> 16) & 'hF), tag);
        rd_expect(b, 8'h00, "R7");
    endtask

    initial begin : watchdog
        #1000000;
        fails++;
        $display("FAIL R10: watchdog expired, got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [7:0] b;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        check(rdata, 8'h00, "R9");
        check(inc_irq | wrap_irq, 8'h00, "R9");

        // R4 / R7: preset every counter in stop mode
        set_stop(1'b1);
        for (int i = 0; i < 8; i++) begin
            known[i] = ((i + 1) * 'h13579) & 'hFFFFF;
            if (i == 7) known[i] = 'hFFFFE;
            b = 8'hA0 + 8'(4 * i);
            put(b + 8'd1, 8'hA0 | 8'((known[i] >> 16) & 'hF), "R7");
            put(b + 8'd3, 8'(known[i] & 'hFF), "R4");
            put(b + 8'd2, 8'((known[i] >> 8) & 'hFF), "R4");
            put(b, 8'hFF, "R7");
        end
        for (int i = 0; i < 8; i++) read_all(i, "R5");

        // R1 / R2: counting and rollover
        set_stop(1'b0);
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 8'h80, "R2");
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 8'h80, "R2");
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 8'h0F, "R1");
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 8'h0F, "R1");
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 8'h0F, "R1");
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 8'h50, "R1");
        known[7] = 0;
        for (int i = 0; i < 4; i++) known[i] += 3;
        known[4] += 1; known[6] += 1;
        set_stop(1'b0);
        read_all(7, "R2");
        read_all(0, "R1");
        read_all(6, "R1");

        // R6: snapshot survives later counting
        rd_expect(8'hA3, 8'(known[0] & 'hFF), "R5");
        for (int n = 0; n < 300; n++) cyc(1'b0, 1'b0, 8'h00, 8'h00, 8'h01, "R6");
        set_stop(1'b0);
        rd_expect(8'hA2, 8'((known[0] >> 8) & 'hFF), "R6");
        known[0] += 300;
        read_all(0, "R6");

        // R6: one shared holding register
        rd_expect(8'hAB, 8'(known[2] & 'hFF), "R6");
        rd_expect(8'hB5, 8'((known[2] >> 16) & 'hF), "R6");
        rd_expect(8'hBE, 8'((known[2] >> 8) & 'hFF), "R6");

        // R3: stop mode holds counts
        set_stop(1'b1);
        for (int n = 0; n < 5; n++) cyc(1'b0, 1'b0, 8'h00, 8'h00, 8'hFF, "R3");
        set_stop(1'b1);
        read_all(1, "R3");

        // R4: writes outside stop mode dropped
        set_stop(1'b0);
        put(8'hA7, 8'h00, "R4");
        put(8'hA6, 8'h00, "R4");
        set_stop(1'b0);
        read_all(1, "R4");

        // R8: reserved addresses
        rd_expect(8'h10, 8'h00, "R8");
        rd_expect(8'h9F, 8'h00, "R8");
        rd_expect(8'hC0, 8'h00, "R8");
        rd_expect(8'hFF, 8'h00, "R8");

        // R9: reset keeps the counts
        @(negedge clk);
        rst = 1'b1; cur_tag = "R9";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rdata, 8'h00, "R9");
        rd_expect(8'hA1, 8'h00, "R9");
        read_all(3, "R9");
        read_all(5, "R9");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule